// File: doc/BRIEF.md
# Local Interrupt Countdown Timer

A per-processor countdown timer that raises an interrupt request after a programmed number of prescaled clock ticks. Software sets up three registers through a simple write port. The first holds the starting count. The second selects the prescale ratio. The third is an interrupt-control word that carries the vector, a mask bit and the timer mode. A fourth read-only register returns the live count, so software can compute elapsed ticks as the starting count minus the live count.

Writing a nonzero starting count loads the live count at once and starts the countdown. Writing zero stops the timer. The timer runs in one of two modes. In one-shot mode it expires once and then holds at zero. In periodic mode it reloads itself one cycle after each expiry. On expiry the timer raises an interrupt request with the programmed vector, unless the mask bit is set. The request stays up until the acknowledge input is pulsed.

Top module: `irq_countdown_timer`

## Requirements
- R1: A write to address 0 loads both the starting count and the live count with the written value and clears the prescaler. The live count, read at address 1, first decrements one full divide period after that write. Writes to address 1 are ignored.
- R2: The divide register (address 2, bits 3:0) selects the prescale ratio: 1011 gives /1, 0000 gives /2, 0001 gives /4, 0010 gives /8, 0011 gives /16, 1000 gives /32, 1001 gives /64 and 1010 gives /128.
- R3: In one-shot mode (mode field 0), the request rises exactly div*N cycles after a write of count N. The live count then stays at zero.
- R4: In periodic mode (mode field 1), the live count reloads the starting count on the cycle after it reaches zero. Successive expiries are therefore div*N+1 cycles apart.
- R5: With the mask bit set, the count still expires and reloads, but no request is raised.
- R6: The request stays asserted until irq_ack is pulsed, and the ack clears it. Bit 12 of the control word reads 1 while a request is pending and 0 otherwise.
- R7: Writing a starting count of zero stops the timer. The live count reads zero and no request is raised.
- R8: Mode field values 2 and 3 freeze the live count.
- R9: The control word at address 3 has the vector in bits 7:0, the mask in bit 16 and the mode in bits 18:17. irq_vec presents the programmed vector. After reset all counts are 0, the divide code is 0000 and the control word reads 0x00010000 (masked).
- R10: A write to the divide register clears the prescaler, so the next decrement comes one full divide period after that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 2 | Register read address |
| rd_data | output | 32 | Register read data (combinational) |
| irq_req | output | 1 | Interrupt request, held until acknowledged |
| irq_vec | output | 8 | Vector of the interrupt request |
| irq_ack | input | 1 | Acknowledge pulse that clears the request |

## Verification
The bench sweeps all eight divide codes in one-shot mode and times each expiry against div*N. A scrambled code decode would produce the wrong interval, and a timer that overshoots zero would show a wrapped count. Periodic runs measure the gap between expiries. A design that skips the reload cycle or reloads late would show a gap other than div*N+1. Further checks cover:
- the masked mode, where a leaky mask would raise a request;
- the frozen mode, where a timer that ignores the mode would keep counting;
- the zero-count stop, where a timer that ignores it would still fire;
- a divide rewrite in the middle of a period, where a prescaler that keeps its phase would decrement early.

// File: rtl/irq_countdown_timer.sv
module irq_countdown_timer #(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 32,
  parameter int VEC_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [1:0]        rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              irq_req,
  output logic [VEC_W-1:0]  irq_vec,
  input  logic              irq_ack
);
  localparam int PS_W = 7;

  logic [CNT_W-1:0] init_q, cnt_q;
  logic [3:0]       div_q;
  logic [VEC_W-1:0] vec_q;
  logic             mask_q, run_q, reload_q, pend_q;
  logic [1:0]       mode_q;
  logic [PS_W-1:0]  ps_q;

  wire wr_init = wr_en && (wr_addr == 2'd0);
  wire wr_div  = wr_en && (wr_addr == 2'd2);
  wire wr_lvt  = wr_en && (wr_addr == 2'd3);

  wire [2:0]      shift    = {div_q[3], div_q[1:0]} + 3'd1;
  wire [PS_W-1:0] div_mask = PS_W'((8'd1 << shift) - 8'd1);
  wire            tick     = (ps_q & div_mask) == div_mask;
  wire            counting = run_q && !mode_q[1] && !reload_q;
  wire            expire   = counting && tick && (cnt_q == CNT_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      init_q   <= '0;
      cnt_q    <= '0;
      run_q    <= 1'b0;
      reload_q <= 1'b0;
    end else if (wr_init) begin
      init_q   <= wr_data[CNT_W-1:0];
      cnt_q    <= wr_data[CNT_W-1:0];
      run_q    <= wr_data[CNT_W-1:0] != '0;
      reload_q <= 1'b0;
    end else if (reload_q) begin
      cnt_q    <= init_q;
      reload_q <= 1'b0;
    end else if (counting && tick) begin
      cnt_q <= cnt_q - CNT_W'(1);
      if (expire) begin
        if (mode_q == 2'd1) reload_q <= 1'b1;
        else                run_q    <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || wr_init || wr_div || reload_q) ps_q <= '0;
    else if (counting)                            ps_q <= ps_q + PS_W'(1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      div_q  <= 4'd0;
      vec_q  <= '0;
      mask_q <= 1'b1;
      mode_q <= 2'd0;
    end else begin
      if (wr_div) div_q <= wr_data[3:0];
      if (wr_lvt) begin
        vec_q  <= wr_data[VEC_W-1:0];
        mask_q <= wr_data[16];
        mode_q <= wr_data[18:17];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                 pend_q <= 1'b0;
    else if (expire && !mask_q) pend_q <= 1'b1;
    else if (irq_ack)           pend_q <= 1'b0;
  end

  assign irq_req = pend_q;
  assign irq_vec = vec_q;

  always_comb begin
    case (rd_addr)
      2'd0:    rd_data = DATA_W'(init_q);
      2'd1:    rd_data = DATA_W'(cnt_q);
      2'd2:    rd_data = DATA_W'(div_q);
      default: begin
        rd_data        = '0;
        rd_data[VEC_W-1:0] = vec_q;
        rd_data[12]    = pend_q;
        rd_data[16]    = mask_q;
        rd_data[18:17] = mode_q;
      end
    endcase
  end

  p_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_init && !reload_q) |=> (cnt_q == $past(cnt_q) || cnt_q == $past(cnt_q) - CNT_W'(1)));
  p_stop_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_q && !wr_init) |=> $stable(cnt_q));
  p_mask_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q && !pend_q) |=> !pend_q);
  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && !irq_ack) |=> pend_q);
  p_ack_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_ack && !expire) |=> !pend_q);
  p_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_init && wr_data[CNT_W-1:0] == '0) |=> (cnt_q == '0 && !run_q));
  p_freeze_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q[1] && !wr_init && !reload_q) |=> $stable(cnt_q));
endmodule

// File: tb/irq_countdown_timer_tb.sv
module irq_countdown_timer_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = 2'd0;
  logic [31:0] wr_data = 32'd0;
  logic [1:0]  rd_addr = 2'd0;
  logic [31:0] rd_data;
  logic        irq_req;
  logic [7:0]  irq_vec;
  logic        irq_ack = 1'b0;

  int compared = 0;
  int mismatched = 0;

  always #10 clk = ~clk;

  irq_countdown_timer u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .irq_req(irq_req), .irq_vec(irq_vec), .irq_ack(irq_ack)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    rd_addr = a;
    #1;
    d = rd_data;
  endtask

  task automatic ack();
    irq_ack = 1'b1;
    @(negedge clk);
    irq_ack = 1'b0;
  endtask

  task automatic wait_irq(output int n);
    n = 0;
    while (!irq_req && n < 5000) begin
      @(negedge clk);
      n++;
    end
  endtask

  initial begin
    #(20 * 150000);
    mismatched++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    logic [31:0] v, c0;
    int n;
    bit seen_irq, saw_zero, saw_reload;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R9 reset state
    rd(2'd0, v); check("R9 reset init", v, 0);
    rd(2'd1, v); check("R9 reset count", v, 0);
    rd(2'd2, v); check("R9 reset div", v, 0);
    rd(2'd3, v); check("R9 reset ctrl", v, 32'h0001_0000);
    check("R9 reset irq", {31'd0, irq_req}, 0);

    // R2/R3 one-shot sweep over all divide codes
    for (int k = 0; k < 8; k++) begin
      int dv;
      logic [3:0] code;
      logic [2:0] km;
      dv = 1 << k;
      km = 3'(k - 1);
      code = (k == 0) ? 4'b1011 : {km[2], 1'b0, km[1:0]};
      wr(2'd3, 32'h20 + k);
      wr(2'd2, {28'd0, code});
      wr(2'd0, 32'd3);
      n = 0;
      while (!irq_req && n < 5000) begin
        @(negedge clk);
        n++;
        if (n == dv) begin
          rd(2'd1, v); check("R1 first decrement", v, 2);
        end
      end
      check("R2 R3 one-shot interval", n, 3 * dv);
      check("R9 irq_vec", {24'd0, irq_vec}, 32'h20 + k);
      rd(2'd3, v); check("R6 status pending", v, 32'h1020 + k);
      rd(2'd1, v); check("R3 count at zero", v, 0);
      repeat (3 * dv + 5) @(negedge clk);
      rd(2'd1, v); check("R3 stays at zero", v, 0);
      ack();
      check("R6 ack clears", {31'd0, irq_req}, 0);
      rd(2'd3, v); check("R6 status idle", v, 32'h20 + k);
    end

    // R4 periodic
    for (int t = 0; t < 2; t++) begin
      int dv, cn;
      dv = (t == 0) ? 1 : 2;
      cn = (t == 0) ? 4 : 3;
      wr(2'd3, 32'h0002_0040);
      wr(2'd2, (t == 0) ? 32'hB : 32'h0);
      wr(2'd0, cn);
      wait_irq(n);
      check("R4 first expiry", n, dv * cn);
      ack();
      n = 1;
      while (!irq_req && n < 5000) begin
        @(negedge clk);
        n++;
      end
      check("R4 periodic gap", n, dv * cn + 1);
      ack();
      wr(2'd0, 32'd0);
      rd(2'd1, v); check("R7 zero write stops", v, 0);
      seen_irq = 0;
      repeat (30) begin
        @(negedge clk);
        if (irq_req) seen_irq = 1;
      end
      check("R7 no irq after zero", {31'd0, seen_irq}, 0);
    end

    // R5 masked periodic
    wr(2'd3, 32'h0003_0041);
    wr(2'd2, 32'hB);
    wr(2'd0, 32'd2);
    seen_irq = 0; saw_zero = 0; saw_reload = 0;
    repeat (20) begin
      @(negedge clk);
      if (irq_req) seen_irq = 1;
      rd(2'd1, v);
      if (v == 0) saw_zero = 1;
      else if (saw_zero && v == 2) saw_reload = 1;
    end
    check("R5 masked no irq", {31'd0, seen_irq}, 0);
    check("R5 masked expiry", {31'd0, saw_zero}, 1);
    check("R5 masked reload", {31'd0, saw_reload}, 1);
    rd(2'd3, v); check("R5 status idle", v, 32'h0003_0041);
    wr(2'd0, 32'd0);

    // R8 frozen mode, R1 count register read-only
    wr(2'd3, 32'h0004_0000);
    wr(2'd0, 32'd5);
    repeat (20) @(negedge clk);
    rd(2'd1, v); check("R8 frozen count", v, 5);
    wr(2'd1, 32'd99);
    rd(2'd1, v); check("R1 count write ignored", v, 5);
    check("R8 no irq", {31'd0, irq_req}, 0);

    // R1 restart, R6 hold
    wr(2'd3, 32'h55);
    wr(2'd0, 32'd50);
    repeat (10) @(negedge clk);
    wr(2'd0, 32'd10);
    rd(2'd1, v); check("R1 restart load", v, 10);
    wait_irq(n);
    check("R1 restart interval", n, 10);
    check("R9 vector 0x55", {24'd0, irq_vec}, 32'h55);
    repeat (10) @(negedge clk);
    check("R6 held without ack", {31'd0, irq_req}, 1);
    ack();
    check("R6 cleared by ack", {31'd0, irq_req}, 0);

    // R10 divide write resets prescaler
    wr(2'd3, 32'h0001_0000);
    wr(2'd2, 32'h2);
    wr(2'd0, 32'd100);
    repeat (5) @(negedge clk);
    wr(2'd2, 32'h2);
    rd(2'd1, c0);
    repeat (7) @(negedge clk);
    rd(2'd1, v); check("R10 no early decrement", v, c0);
    @(negedge clk);
    rd(2'd1, v); check("R10 decrement after period", v, c0 - 1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule